// File: doc/BRIEF.md
# Delta-Gated Sparse GRU Layer Engine

This block evaluates one gated-recurrent layer per incoming feature frame, and it does work only for the values that moved. When a frame is accepted, every input feature and every hidden-state value from the previous frame is compared with the last value the engine actually propagated for that position. A position whose change in magnitude is larger than a programmable threshold is marked as firing. Each firing position gets its signed change multiplied into the matching weight columns. All other positions cost no cycles, no weight fetches and no arithmetic.

Every neuron has four pre-activation accumulators: reset gate, update gate, the input part of the candidate, and the recurrent part of the candidate. These accumulators persist from frame to frame. Adding change times weight keeps each one equal to the full product of the weights with the propagated values. Once the firing positions are done, a fixed-length pass applies a hard sigmoid and a hard tanh to each neuron in turn and writes the new hidden state.

Weights are fetched through a synchronous read port, two signed 8-bit weights per 16-bit word. The feature source, the classifier behind the layer and the weight storage itself sit outside the block.

Top module: `delta_gru_layer`

## Requirements
- R1: While reset is high and after it is released, the hidden state reads all zero, done, overrun and mem_ren are low, and every propagated reference value is zero.
- R2: Position e fires in a frame only if |value - reference| > thresh, with thresh a 9-bit unsigned value. With thresh = 0 the hidden state equals a dense GRU evaluation of the same frames. With thresh above 255 nothing fires.
- R3: A reference is replaced by the current value only when its position fires. Changes below the threshold therefore add up over frames until their total crosses the threshold.
- R4: Positions 0..9 are the input features frame_x[8e+7:8e]. Positions 10..73 are the hidden values h_out[8j+7:8j] (j = e-10) held at the moment the frame is accepted.
- R5: Each firing position e issues exactly 96 reads, at addresses 96e + 32g + p for gate g (0 reset, 1 update, 2 candidate) and pair p = 0..31. A position that does not fire issues none. The reads in a frame total 96 times the number of firing positions.
- R6: mem_rdata is sampled one cycle after the read is issued. Bits [7:0] hold the signed weight for neuron 2p and bits [15:8] hold the signed weight for neuron 2p+1.
- R7: The accumulators persist across frames and are signed 18-bit values with Q.12 scaling. Each update saturates to [-131072, 131071] and never wraps.
- R8: With r = clamp((a_r>>>8)+32, 0, 64) and u the same formula on a_u, the engine computes c = clamp((a_cx + ((r*a_ch)>>>6))>>>6, -64, 64) and h' = (u*h + (64-u)*c)>>>6. All values are Q.6.
- R9: done is a single-cycle pulse in the cycle after the final hidden-state write. h_out changes only during the activation pass.
- R10: A frame_valid that arrives while a frame is in progress is ignored. It causes a one-cycle overrun pulse in the following cycle and changes neither the reads nor the hidden state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_valid | input | 1 | Accept frame_x as a new frame (when idle) |
| frame_x | input | 80 | Ten signed Q.6 input features, feature e at bits [8e+7:8e] |
| thresh | input | 9 | Unsigned firing threshold on the magnitude of change |
| overrun | output | 1 | One-cycle pulse: a frame arrived while busy and was dropped |
| mem_ren | output | 1 | Weight read strobe |
| mem_addr | output | 13 | Weight word address |
| mem_rdata | input | 16 | Weight word, returned one cycle after the read |
| h_out | output | 512 | Sixty-four signed Q.6 hidden values |
| done | output | 1 | One-cycle pulse when the hidden state for a frame is complete |

## Verification
The drift case sends small steps that stay under the threshold when taken frame by frame but cross it in total. A design that compares against the previous frame instead of the last propagated value would never fire here, and it would issue too few reads. An all-above-threshold case checks that nothing is fetched and that the hidden state still follows the gate mixing. A saturating case drives the update-gate and candidate accumulators beyond the 18-bit range with opposite signs. A design that wraps instead of clamping would return zero instead of full scale. A second frame that arrives mid-computation must produce an overrun pulse and leave both the read count and the hidden state matching a single-frame model. A design that queued or restarted on that frame would show extra reads or a wrong state.

// File: rtl/dgru_pkg.sv
`timescale 1ns/1ps
package dgru_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MAC   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_ACT   = 2'd3
  } dg_state_e;

  // accumulator bank selector
  typedef enum logic [1:0] {
    SEL_R  = 2'd0,
    SEL_U  = 2'd1,
    SEL_CX = 2'd2,
    SEL_CH = 2'd3
  } acc_sel_e;

  localparam int GATE_COUNT = 3;
endpackage

// File: rtl/dgru_delta_gate.sv
`timescale 1ns/1ps
module dgru_delta_gate #(
  parameter int N_IN  = 10,
  parameter int N_HID = 64,
  parameter int DW    = 8
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               capture,
  input  logic [DW:0]                        thresh,
  input  logic [N_IN*DW-1:0]                 x_flat,
  input  logic [N_HID*DW-1:0]                h_flat,
  output logic [N_IN+N_HID-1:0]              fire,
  output logic [(N_IN+N_HID)*(DW+1)-1:0]     delta_flat
);
  localparam int N_EL = N_IN + N_HID;
  localparam int DDW  = DW + 1;

  for (genvar e = 0; e < N_EL; e++) begin : g_el
    logic signed [DW-1:0]  cur;
    logic signed [DW-1:0]  ref_q;
    logic signed [DDW-1:0] diff;
    logic        [DDW-1:0] mag;
    logic signed [DDW-1:0] dq;

    if (e < N_IN) begin : g_x
      assign cur = x_flat[e*DW +: DW];
    end else begin : g_h
      assign cur = h_flat[(e-N_IN)*DW +: DW];
    end

    assign diff = $signed({cur[DW-1], cur}) - $signed({ref_q[DW-1], ref_q});
    assign mag  = diff[DDW-1] ? DDW'(-diff) : DDW'(diff);
    assign fire[e] = (mag > thresh);
    assign delta_flat[e*DDW +: DDW] = dq;

    always_ff @(posedge clk) begin
      if (rst) begin
        ref_q <= '0;
        dq    <= '0;
      end else if (capture) begin
        if (fire[e]) ref_q <= cur;
        dq <= fire[e] ? diff : '0;
      end
    end
  end
endmodule

// File: rtl/dgru_scan.sv
`timescale 1ns/1ps
module dgru_scan #(
  parameter int N_EL = 74,
  parameter int IW   = $clog2(N_EL)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [N_EL-1:0] load_mask,
  input  logic            consume,
  output logic            valid,
  output logic [IW-1:0]   idx
);
  logic [N_EL-1:0] mask_q;

  // lowest pending position wins
  always_comb begin
    idx   = '0;
    valid = |mask_q;
    for (int i = N_EL-1; i >= 0; i--) begin
      if (mask_q[i]) idx = IW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (load)    mask_q <= load_mask;
    else if (consume) mask_q[idx] <= 1'b0;
  end
endmodule

// File: rtl/dgru_acc_bank.sv
`timescale 1ns/1ps
module dgru_acc_bank #(
  parameter int N_HID = 64,
  parameter int DW    = 8,
  parameter int WW    = 8,
  parameter int ACC_W = 18,
  parameter int PW    = $clog2(N_HID/2),
  parameter int NW    = $clog2(N_HID)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    upd_en,
  input  logic [1:0]              upd_sel,
  input  logic [PW-1:0]           upd_pair,
  input  logic signed [DW:0]      upd_delta,
  input  logic [2*WW-1:0]         upd_word,
  input  logic [NW-1:0]           rd_idx,
  output logic signed [ACC_W-1:0] rd_r,
  output logic signed [ACC_W-1:0] rd_u,
  output logic signed [ACC_W-1:0] rd_cx,
  output logic signed [ACC_W-1:0] rd_ch
);
  localparam int PRW = DW + 1 + WW;
  localparam logic signed [ACC_W-1:0] MAXV = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] MINV = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W-1:0] acc_q [4][N_HID];
  logic signed [ACC_W-1:0] nxt   [2];
  logic        [NW-1:0]    nidx  [2];

  always_comb begin
    for (int k = 0; k < 2; k++) begin
      logic signed [WW-1:0]  w;
      logic signed [PRW-1:0] prod;
      logic signed [ACC_W:0] sum;
      w       = upd_word[k*WW +: WW];
      prod    = upd_delta * w;
      nidx[k] = NW'({upd_pair, 1'(k)});
      sum     = (ACC_W+1)'(acc_q[upd_sel][nidx[k]]) + (ACC_W+1)'(prod);
      if (sum[ACC_W] != sum[ACC_W-1]) nxt[k] = sum[ACC_W] ? MINV : MAXV;
      else                            nxt[k] = sum[ACC_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < 4; s++)
        for (int n = 0; n < N_HID; n++)
          acc_q[s][n] <= '0;
    end else if (upd_en) begin
      for (int k = 0; k < 2; k++)
        acc_q[upd_sel][nidx[k]] <= nxt[k];
    end
  end

  assign rd_r  = acc_q[0][rd_idx];
  assign rd_u  = acc_q[1][rd_idx];
  assign rd_cx = acc_q[2][rd_idx];
  assign rd_ch = acc_q[3][rd_idx];
endmodule

// File: rtl/dgru_act.sv
`timescale 1ns/1ps
module dgru_act #(
  parameter int DW    = 8,
  parameter int ACC_W = 18,
  parameter int FRAC  = 6
) (
  input  logic signed [ACC_W-1:0] acc_r,
  input  logic signed [ACC_W-1:0] acc_u,
  input  logic signed [ACC_W-1:0] acc_cx,
  input  logic signed [ACC_W-1:0] acc_ch,
  input  logic signed [DW-1:0]    h_prev,
  output logic signed [DW-1:0]    h_new
);
  localparam int ONE = 1 << FRAC;
  localparam int GW  = FRAC + 3;
  localparam int EW  = ACC_W + FRAC + 4;

  function automatic logic signed [GW-1:0] hsig(input logic signed [ACC_W-1:0] a);
    logic signed [ACC_W-1:0] t;
    t = (a >>> (FRAC+2)) + ACC_W'(ONE/2);
    if (t < 0)        return '0;
    else if (t > ONE) return GW'(ONE);
    else              return t[GW-1:0];
  endfunction

  logic signed [GW-1:0] r_g, u_g, c_g;
  logic signed [EW-1:0] rch, pre, tq, mix;

  always_comb begin
    r_g = hsig(acc_r);
    u_g = hsig(acc_u);
    rch = EW'(r_g) * EW'(acc_ch);
    pre = EW'(acc_cx) + (rch >>> FRAC);
    tq  = pre >>> FRAC;
    if (tq > EW'(ONE))       c_g = GW'(ONE);
    else if (tq < -EW'(ONE)) c_g = -GW'(ONE);
    else                     c_g = tq[GW-1:0];
    mix   = EW'(u_g) * EW'(h_prev) + (EW'(ONE) - EW'(u_g)) * EW'(c_g);
    h_new = DW'(mix >>> FRAC);
  end
endmodule

// File: rtl/delta_gru_layer.sv
`timescale 1ns/1ps
module delta_gru_layer
  import dgru_pkg::*;
#(
  parameter int N_IN  = 10,
  parameter int N_HID = 64,
  parameter int DW    = 8,
  parameter int WW    = 8,
  parameter int ACC_W = 18,
  parameter int FRAC  = 6,
  localparam int AW   = $clog2((N_IN+N_HID)*GATE_COUNT*(N_HID/2))
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frame_valid,
  input  logic [N_IN*DW-1:0]  frame_x,
  input  logic [DW:0]         thresh,
  output logic                overrun,
  output logic                mem_ren,
  output logic [AW-1:0]       mem_addr,
  input  logic [2*WW-1:0]     mem_rdata,
  output logic [N_HID*DW-1:0] h_out,
  output logic                done
);
  localparam int N_EL  = N_IN + N_HID;
  localparam int PAIRS = N_HID / 2;
  localparam int ROWS  = GATE_COUNT * PAIRS;
  localparam int PW    = $clog2(PAIRS);
  localparam int NW    = $clog2(N_HID);
  localparam int IW    = $clog2(N_EL);
  localparam int DDW   = DW + 1;

  dg_state_e             state_q;
  logic [1:0]            gate_q;
  logic [PW-1:0]         pair_q;
  logic [NW-1:0]         act_n;
  logic signed [DW-1:0]  h_q [N_HID];

  // read pipeline: s0 travels with the issued address, s1 with the returned word
  acc_sel_e              s0_sel, s1_sel;
  logic [PW-1:0]         s0_pair, s1_pair;
  logic signed [DDW-1:0] s0_delta, s1_delta;
  logic                  s1_en;

  logic                  capture, consume, scan_valid, busy_w, act_w;
  logic [IW-1:0]         scan_idx;
  logic [N_EL-1:0]       fire;
  logic [N_EL*DDW-1:0]   delta_flat;
  logic signed [DDW-1:0] cur_delta;
  acc_sel_e              issue_sel;
  logic signed [ACC_W-1:0] a_r, a_u, a_cx, a_ch;
  logic signed [DW-1:0]  h_next;

  assign busy_w    = (state_q != ST_IDLE);
  assign act_w     = (state_q == ST_ACT);
  assign capture   = (state_q == ST_IDLE) && frame_valid;
  assign consume   = (state_q == ST_MAC) && scan_valid &&
                     (pair_q == PW'(PAIRS-1)) && (gate_q == 2'(GATE_COUNT-1));
  assign cur_delta = delta_flat[scan_idx*DDW +: DDW];

  always_comb begin
    if (gate_q == 2'(GATE_COUNT-1))
      issue_sel = (int'(scan_idx) >= N_IN) ? SEL_CH : SEL_CX;
    else
      issue_sel = acc_sel_e'(gate_q);
  end

  for (genvar n = 0; n < N_HID; n++) begin : g_hout
    assign h_out[n*DW +: DW] = h_q[n];
  end

  dgru_delta_gate #(.N_IN(N_IN), .N_HID(N_HID), .DW(DW)) u_gate (
    .clk(clk), .rst(rst), .capture(capture), .thresh(thresh),
    .x_flat(frame_x), .h_flat(h_out), .fire(fire), .delta_flat(delta_flat)
  );

  dgru_scan #(.N_EL(N_EL), .IW(IW)) u_scan (
    .clk(clk), .rst(rst), .load(capture), .load_mask(fire),
    .consume(consume), .valid(scan_valid), .idx(scan_idx)
  );

  dgru_acc_bank #(.N_HID(N_HID), .DW(DW), .WW(WW), .ACC_W(ACC_W), .PW(PW), .NW(NW)) u_acc (
    .clk(clk), .rst(rst), .upd_en(s1_en), .upd_sel(s1_sel), .upd_pair(s1_pair),
    .upd_delta(s1_delta), .upd_word(mem_rdata), .rd_idx(act_n),
    .rd_r(a_r), .rd_u(a_u), .rd_cx(a_cx), .rd_ch(a_ch)
  );

  dgru_act #(.DW(DW), .ACC_W(ACC_W), .FRAC(FRAC)) u_act (
    .acc_r(a_r), .acc_u(a_u), .acc_cx(a_cx), .acc_ch(a_ch),
    .h_prev(h_q[act_n]), .h_new(h_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      gate_q   <= '0;
      pair_q   <= '0;
      act_n    <= '0;
      mem_ren  <= 1'b0;
      mem_addr <= '0;
      done     <= 1'b0;
      overrun  <= 1'b0;
      s0_sel   <= SEL_R;
      s0_pair  <= '0;
      s0_delta <= '0;
      s1_en    <= 1'b0;
      s1_sel   <= SEL_R;
      s1_pair  <= '0;
      s1_delta <= '0;
      for (int n = 0; n < N_HID; n++) h_q[n] <= '0;
    end else begin
      mem_ren  <= 1'b0;
      done     <= 1'b0;
      overrun  <= frame_valid && busy_w;
      s1_en    <= mem_ren;
      s1_sel   <= s0_sel;
      s1_pair  <= s0_pair;
      s1_delta <= s0_delta;
      case (state_q)
        ST_IDLE: begin
          if (frame_valid) begin
            state_q <= ST_MAC;
            gate_q  <= '0;
            pair_q  <= '0;
          end
        end
        ST_MAC: begin
          if (scan_valid) begin
            mem_ren  <= 1'b1;
            mem_addr <= AW'(scan_idx) * AW'(ROWS) + AW'(gate_q) * AW'(PAIRS) + AW'(pair_q);
            s0_sel   <= issue_sel;
            s0_pair  <= pair_q;
            s0_delta <= cur_delta;
            if (pair_q == PW'(PAIRS-1)) begin
              pair_q <= '0;
              gate_q <= (gate_q == 2'(GATE_COUNT-1)) ? 2'd0 : gate_q + 2'd1;
            end else begin
              pair_q <= pair_q + PW'(1);
            end
          end else begin
            state_q <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          state_q <= ST_ACT;
          act_n   <= '0;
        end
        ST_ACT: begin
          h_q[act_n] <= h_next;
          if (act_n == NW'(N_HID-1)) begin
            state_q <= ST_IDLE;
            done    <= act_w;
          end else begin
            act_n <= act_n + NW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dgru_checker.sv
`timescale 1ns/1ps
module dgru_checker #(
  parameter int AW   = 13,
  parameter int HW   = 512,
  parameter int MAXA = 7104
) (
  input logic          clk,
  input logic          rst,
  input logic          frame_valid,
  input logic          busy,
  input logic          in_act,
  input logic          done,
  input logic          overrun,
  input logic          mem_ren,
  input logic [AW-1:0] mem_addr,
  input logic [HW-1:0] h_out
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!done && !overrun && !mem_ren && (h_out == '0)));

  a_r5_addr_in_range: assert property (@(posedge clk) disable iff (rst)
    mem_ren |-> (int'(mem_addr) < MAXA));

  a_r5_read_only_busy: assert property (@(posedge clk) disable iff (rst)
    mem_ren |-> busy);

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_done_follows_act: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(in_act));

  a_r9_state_moves_in_act: assert property (@(posedge clk) disable iff (rst)
    !$stable(h_out) |-> $past(in_act));

  a_r10_overrun_flag: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && busy) |=> overrun);

  a_r10_overrun_only_busy: assert property (@(posedge clk) disable iff (rst)
    overrun |-> $past(busy));
endmodule

bind delta_gru_layer dgru_checker #(
  .AW(AW), .HW(N_HID*DW), .MAXA(N_EL*ROWS)
) u_chk (
  .clk(clk), .rst(rst), .frame_valid(frame_valid), .busy(busy_w), .in_act(act_w),
  .done(done), .overrun(overrun), .mem_ren(mem_ren), .mem_addr(mem_addr), .h_out(h_out)
);

// File: tb/sim_delta_gru_layer.sv
`timescale 1ns/1ps
module sim_delta_gru_layer;
  localparam int NI = 10, NH = 64, DW = 8, PAIRS = 32, ROWS = 96, AW = 13;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              frame_valid = 1'b0;
  logic [NI*DW-1:0]  frame_x = '0;
  logic [DW:0]       thresh = '0;
  logic              overrun, mem_ren, done;
  logic [AW-1:0]     mem_addr;
  logic [15:0]       mem_rdata = '0;
  logic [NH*DW-1:0]  h_out;

  int total = 0, bad = 0, reads = 0, wmode = 0, last_active = 0;
  int ref_x [NI];
  int ref_h [NH];
  int mh    [NH];

  always #10 clk = ~clk;

  delta_gru_layer u0 (
    .clk(clk), .rst(rst), .frame_valid(frame_valid), .frame_x(frame_x),
    .thresh(thresh), .overrun(overrun), .mem_ren(mem_ren), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .h_out(h_out), .done(done)
  );

  function automatic int wt(int a, int half);
    if (wmode == 1) return (((a % ROWS) / PAIRS) == 1) ? -127 : 127;
    return ((a*13 + half*5 + (a >> 2)) % 7) - 3;
  endfunction

  // synchronous weight store, one-cycle latency
  always @(posedge clk) begin
    if (mem_ren) begin
      mem_rdata <= {8'(wt(int'(mem_addr), 1)), 8'(wt(int'(mem_addr), 0))};
      reads     <= reads + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int clampi(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  task automatic model_frame(input logic [NI*DW-1:0] xv, input int th);
    int v, d;
    last_active = 0;
    for (int i = 0; i < NI; i++) begin
      v = int'($signed(xv[i*DW +: DW]));
      d = v - ref_x[i];
      if (((d < 0) ? -d : d) > th) begin ref_x[i] = v; last_active++; end
    end
    for (int j = 0; j < NH; j++) begin
      d = mh[j] - ref_h[j];
      if (((d < 0) ? -d : d) > th) begin ref_h[j] = mh[j]; last_active++; end
    end
    for (int n = 0; n < NH; n++) begin
      int ar, au, acx, ach, r, u, c, val, w;
      ar = 0; au = 0; acx = 0; ach = 0;
      for (int e = 0; e < NI + NH; e++) begin
        val = (e < NI) ? ref_x[e] : ref_h[e-NI];
        for (int g = 0; g < 3; g++) begin
          w = wt(e*ROWS + g*PAIRS + n/2, n % 2);
          if (g == 0)      ar += val * w;
          else if (g == 1) au += val * w;
          else if (e < NI) acx += val * w;
          else             ach += val * w;
        end
      end
      ar  = clampi(ar,  -131072, 131071);
      au  = clampi(au,  -131072, 131071);
      acx = clampi(acx, -131072, 131071);
      ach = clampi(ach, -131072, 131071);
      r = clampi((ar >>> 8) + 32, 0, 64);
      u = clampi((au >>> 8) + 32, 0, 64);
      c = clampi((acx + ((r * ach) >>> 6)) >>> 6, -64, 64);
      mh[n] = (u * mh[n] + (64 - u) * c) >>> 6;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < NI; i++) ref_x[i] = 0;
    for (int j = 0; j < NH; j++) begin ref_h[j] = 0; mh[j] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    check(done, req, "done seen", int'(done), 1);
  endtask

  task automatic cmp_h(input string req);
    int mism = 0, fa = 0, fe = 0, hv;
    for (int n = 0; n < NH; n++) begin
      hv = int'($signed(h_out[n*DW +: DW]));
      if (hv != mh[n]) begin
        if (mism == 0) begin fa = hv; fe = mh[n]; end
        mism++;
      end
    end
    check(mism == 0, req, "hidden state", fa, fe);
  endtask

  task automatic run_frame(input logic [NI*DW-1:0] xv, input int th, input string req);
    int r0;
    @(negedge clk);
    frame_x = xv;
    thresh  = 9'(th);
    model_frame(xv, th);
    r0 = reads;
    frame_valid = 1'b1;
    @(negedge clk);
    frame_valid = 1'b0;
    wait_done(req);
    check((reads - r0) == last_active * ROWS, {req, " R5"}, "reads", reads - r0, last_active * ROWS);
    cmp_h(req);
  endtask

  function automatic logic [NI*DW-1:0] fill(int base, int step, int alt);
    logic [NI*DW-1:0] v;
    for (int i = 0; i < NI; i++)
      v[i*DW +: DW] = 8'(base + step*i + (((i % 2) == 1) ? alt : -alt));
    return v;
  endfunction

  task automatic t_reset();
    do_reset();
    check(h_out == '0, "R1", "h_out zero", 0, 0);
    check(!done,    "R1", "done low", int'(done), 0);
    check(!overrun, "R1", "overrun low", int'(overrun), 0);
    check(!mem_ren, "R1", "mem_ren low", int'(mem_ren), 0);
  endtask

  task automatic t_dense();
    logic [NH*DW-1:0] snap;
    wmode = 0;
    do_reset();
    run_frame(fill(-40, 9, 0), 0, "R2 R4 R6 R8 dense ramp");
    @(negedge clk);
    check(!done, "R9", "done width", int'(done), 0);
    snap = h_out;
    repeat (5) @(negedge clk);
    check(h_out == snap, "R9", "h stable while idle", 0, 0);
    run_frame(fill(0, 0, 100), 0, "R2 R7 dense alternating");
    run_frame(fill(0, 0, 100), 0, "R4 hidden-only change");
    run_frame(fill(60, -11, 17), 0, "R7 dense mixed");
  endtask

  task automatic t_skip();
    run_frame(fill(3, 1, 2), 300, "R2 threshold blocks all");
    check(last_active == 0, "R2", "model active", last_active, 0);
  endtask

  task automatic t_drift();
    int r0;
    wmode = 0;
    do_reset();
    run_frame(fill(20, 0, 0), 10, "R3 first step");
    r0 = reads;
    run_frame(fill(26, 0, 0), 10, "R3 sub-threshold step");
    run_frame(fill(32, 0, 0), 10, "R3 accumulated drift");
    check(reads - r0 >= NI * ROWS, "R3", "drift fires inputs", reads - r0, NI * ROWS);
  endtask

  task automatic t_overrun();
    int r0, r1;
    wmode = 0;
    do_reset();
    @(negedge clk);
    frame_x = fill(-25, 5, 30);
    thresh  = '0;
    model_frame(frame_x, 0);
    r0 = reads;
    frame_valid = 1'b1;
    @(negedge clk);
    frame_valid = 1'b0;
    repeat (5) @(negedge clk);
    frame_x = fill(90, -3, 0);
    frame_valid = 1'b1;
    @(negedge clk);
    frame_valid = 1'b0;
    check(overrun, "R10", "overrun pulse", int'(overrun), 1);
    @(negedge clk);
    check(!overrun, "R10", "overrun width", int'(overrun), 0);
    wait_done("R10");
    check((reads - r0) == last_active * ROWS, "R10 R5", "reads", reads - r0, last_active * ROWS);
    cmp_h("R10");
    r1 = reads;
    repeat (100) @(negedge clk);
    check(reads == r1, "R10", "no deferred frame", reads - r1, 0);
  endtask

  task automatic t_saturate();
    wmode = 1;
    do_reset();
    run_frame(fill(127, 0, 0), 0, "R7 saturation");
    check(int'($signed(h_out[7:0])) == 64, "R7", "neuron0 full scale",
          int'($signed(h_out[7:0])), 64);
    wmode = 0;
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin
    t_reset();
    t_dense();
    t_skip();
    t_drift();
    t_overrun();
    t_saturate();
    finish_up();
  end
endmodule